// File: doc/BRIEF.md
# Programmable Clock Divider with Start Level and Coarse Phase Offset

The block produces one divided clock from a fast input clock. The output period is built from two separately programmed counts: a high count N gives N+1 input cycles of high level, and a low count M gives M+1 input cycles of low level. The division ratio is therefore N+M+2.

When the ratio is odd, an optional duty-correction mode stretches the high phase by half an input cycle. It does this with a falling-edge flop, so that M = N+1 yields exactly 50 % duty.

A sync input restarts the divider. While sync is held, the output rests at an idle level. The idle level is low, or high when the start-high bit is set. On release, every configuration field is frozen in shadow registers. The first rising edge of the output is then placed a programmed number of input cycles after the release. With start-high set, that delay also includes the M+1 low cycles that precede the first rise. A bypass control passes the input clock straight to the output.

Top module: `clkdiv_phase`

## Requirements
- R1: While reset is asserted, and after reset until the first sync pulse, the output is low.
- R2: Without stretching, the output is high for N+1 and low for M+1 input cycles, repeating with a period of N+M+2 cycles. An even ratio with M = N gives 50 % duty.
- R3: When duty correction is enabled and N+M is odd, the high time is N+1.5 input cycles and the period stays N+M+2 cycles. M = N+1 then gives equal high and low times. When N+M is even, enabling correction changes nothing.
- R4: Call E0 the first rising clock edge that samples sync low. With start-high clear, the first output rise happens at E0 + PO input cycles, where PO is the 4-bit offset (0 to 15). Until that rise the output stays low.
- R5: With start-high set, the output stays high for PO cycles from E0 and then falls. The first rise happens at E0 + PO + M + 1 cycles.
- R6: From the first clock edge that samples sync high, and for as long as sync stays high, the output holds the idle level. The idle level is low when start-high is 0 and high when it is 1.
- R7: N, M, PO, start-high and duty correction are captured at each clock edge that samples sync high, and are frozen otherwise. Changing them while the divider runs does not alter its period, high time or phase.
- R8: While bypass is 1, the output equals the input clock. This holds for both levels of the input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Restart request, active high, level held |
| cfg_hi_i | input | 4 | High count N (high phase lasts N+1 cycles) |
| cfg_lo_i | input | 4 | Low count M (low phase lasts M+1 cycles) |
| cfg_ofs_i | input | 4 | Phase offset PO in input cycles |
| cfg_sh_i | input | 1 | Start-high select, also the idle level during sync |
| cfg_bypass_i | input | 1 | 1 = output is the input clock |
| cfg_dcc_i | input | 1 | 1 = half-cycle stretch of the high phase for odd ratios |
| div_clk_o | output | 1 | Divided clock |

## Verification
A wrong phase count or a stale reload value appears as a wrong high time or period within a single output period. A wrong offset count appears in the first rise after sync release, at most 15+16 cycles later. A shadow register that fails to freeze shows as a shifted period on the very next phase boundary after a configuration write. A stuck half-cycle flop shows as a high time off by exactly 5 ns on odd ratios. The bench therefore times the first edge, the high time and one full period after each restart, including restarts whose configuration is scrambled while the divider runs.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // Default width of the high, low and offset fields
    localparam int unsigned DEF_CNT_W = 4;

    // Divider sequencing phases
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,  // after reset, waiting for the first sync
        PH_HOLD  = 3'd1,  // sync held, output at idle level
        PH_DELAY = 3'd2,  // counting the phase offset
        PH_HIGH  = 3'd3,  // high part of the period
        PH_LOW   = 3'd4   // low part of the period
    } phase_e;

endpackage

// File: rtl/clkdiv_shadow.sv
`timescale 1ns/1ps
module clkdiv_shadow #(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] ofs_i,
    input  logic             sh_i,
    input  logic             dcc_i,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o,
    output logic [CNT_W-1:0] ofs_o,
    output logic             sh_o,
    output logic             dcc_o
);

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] ofs;
        logic             sh;
        logic             dcc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Capture on every edge that sees sync high; the last one wins
    always_comb begin
        cfg_d = cfg_q;
        if (sync_i) begin
            cfg_d.hi  = hi_i;
            cfg_d.lo  = lo_i;
            cfg_d.ofs = ofs_i;
            cfg_d.sh  = sh_i;
            cfg_d.dcc = dcc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign hi_o  = cfg_q.hi;
    assign lo_o  = cfg_q.lo;
    assign ofs_o = cfg_q.ofs;
    assign sh_o  = cfg_q.sh;
    assign dcc_o = cfg_q.dcc;

    AST_SHADOW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_i |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic             live_sh_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] ofs_i,
    input  logic             sh_i,
    output logic             out_o
);

    localparam int unsigned LEN_W = CNT_W + 1;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } seq_t;

    seq_t st_d, st_q, launch;

    // First period state after the offset has elapsed
    always_comb begin
        launch = st_q;
        if (sh_i) begin
            launch.ph  = PH_LOW;
            launch.cnt = lo_i;
            launch.out = 1'b0;
        end else begin
            launch.ph  = PH_HIGH;
            launch.cnt = hi_i;
            launch.out = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.ph  = PH_HOLD;
            st_d.cnt = '0;
            st_d.out = live_sh_i;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d = st_q;
                end
                PH_HOLD: begin
                    if (ofs_i != '0) begin
                        st_d.ph  = PH_DELAY;
                        st_d.cnt = ofs_i - 1'b1;
                        st_d.out = sh_i;
                    end else begin
                        st_d = launch;
                    end
                end
                PH_DELAY: begin
                    if (st_q.cnt == '0) begin
                        st_d = launch;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_LOW;
                        st_d.cnt = lo_i;
                        st_d.out = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_HIGH;
                        st_d.cnt = hi_i;
                        st_d.out = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                    st_d.out = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph  <= PH_IDLE;
            st_q.cnt <= '0;
            st_q.out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // Cycles spent in the current phase, kept for the checks below
    logic [LEN_W-1:0] len_d, len_q;

    always_comb begin
        if (st_d.ph != st_q.ph) begin
            len_d = '0;
        end else if (len_q != '1) begin
            len_d = len_q + 1'b1;
        end else begin
            len_d = len_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            len_q <= '0;
        end else begin
            len_q <= len_d;
        end
    end

    AST_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_HIGH && !sync_i && len_q < {1'b0, hi_i}) |=> st_q.ph == PH_HIGH); // R2
    AST_HIGH_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_HIGH && !sync_i && len_q == {1'b0, hi_i}) |=> (st_q.ph == PH_LOW && !out_o)); // R2
    AST_LOW_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_LOW && !sync_i && len_q == {1'b0, lo_i}) |=> (st_q.ph == PH_HIGH && out_o)); // R2
    AST_OFFSET_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_DELAY) |-> out_o == sh_i); // R4
    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_IDLE) |-> !out_o); // R1

endmodule

// File: rtl/clkdiv_dcc.sv
`timescale 1ns/1ps
module clkdiv_dcc (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic core_i,
    input  logic stretch_i,
    input  logic bypass_i,
    output logic clk_o
);

    logic half_d, half_q;

    // Falling-edge copy of the core level extends each high phase by half a cycle
    always_comb begin
        half_d = core_i & stretch_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q <= 1'b0;
        end else begin
            half_q <= half_d;
        end
    end

    assign clk_o = bypass_i ? clk_i : (core_i | half_q);

    AST_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stretch_i && !bypass_i) |-> clk_o == core_i); // R3

endmodule

// File: rtl/clkdiv_phase.sv
`timescale 1ns/1ps
module clkdiv_phase #(
    parameter int unsigned CNT_W = clkdiv_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] cfg_hi_i,
    input  logic [CNT_W-1:0] cfg_lo_i,
    input  logic [CNT_W-1:0] cfg_ofs_i,
    input  logic             cfg_sh_i,
    input  logic             cfg_bypass_i,
    input  logic             cfg_dcc_i,
    output logic             div_clk_o
);

    logic [CNT_W-1:0] hi_q, lo_q, ofs_q;
    logic             sh_q, dcc_q;
    logic             core;
    logic             stretch;

    clkdiv_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_i),
        .hi_i   (cfg_hi_i),
        .lo_i   (cfg_lo_i),
        .ofs_i  (cfg_ofs_i),
        .sh_i   (cfg_sh_i),
        .dcc_i  (cfg_dcc_i),
        .hi_o   (hi_q),
        .lo_o   (lo_q),
        .ofs_o  (ofs_q),
        .sh_o   (sh_q),
        .dcc_o  (dcc_q)
    );

    clkdiv_seq #(.CNT_W(CNT_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sync_i    (sync_i),
        .live_sh_i (cfg_sh_i),
        .hi_i      (hi_q),
        .lo_i      (lo_q),
        .ofs_i     (ofs_q),
        .sh_i      (sh_q),
        .out_o     (core)
    );

    // Odd ratio means N+M odd, i.e. the low bits differ
    assign stretch = dcc_q & (hi_q[0] ^ lo_q[0]);

    clkdiv_dcc u_dcc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .core_i    (core),
        .stretch_i (stretch),
        .bypass_i  (cfg_bypass_i),
        .clk_o     (div_clk_o)
    );

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && $past(sync_i) && !cfg_bypass_i && $stable(cfg_sh_i)) |-> div_clk_o == cfg_sh_i); // R6

endmodule

// File: tb/sim_clkdiv_phase.sv
`timescale 1ns/1ps
module sim_clkdiv_phase;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       sync_i = 1'b0;
    logic [3:0] cfg_hi_i = '0;
    logic [3:0] cfg_lo_i = '0;
    logic [3:0] cfg_ofs_i = '0;
    logic       cfg_sh_i = 1'b0;
    logic       cfg_bypass_i = 1'b0;
    logic       cfg_dcc_i = 1'b0;
    logic       div_clk_o;

    clkdiv_phase u0 (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sync_i       (sync_i),
        .cfg_hi_i     (cfg_hi_i),
        .cfg_lo_i     (cfg_lo_i),
        .cfg_ofs_i    (cfg_ofs_i),
        .cfg_sh_i     (cfg_sh_i),
        .cfg_bypass_i (cfg_bypass_i),
        .cfg_dcc_i    (cfg_dcc_i),
        .div_clk_o    (div_clk_o)
    );

    always #5 clk_i = ~clk_i;

    typedef struct {
        longint t0;
        longint dly;
        longint high;
        longint per;
        string  tag_d;
        string  tag_h;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    pushed = 0;
    int    done   = 0;
    bit    finished = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: restart with a configuration, push the expected timing
    task automatic run_case(input int n, input int m, input int po, input bit sh,
                            input bit dcc, input bit scramble);
        item_t it;
        @(negedge clk_i);
        cfg_hi_i  = 4'(n);
        cfg_lo_i  = 4'(m);
        cfg_ofs_i = 4'(po);
        cfg_sh_i  = sh;
        cfg_dcc_i = dcc;
        sync_i    = 1'b1;
        repeat (2) @(negedge clk_i);
        sync_i = 1'b0;
        it.t0   = $time + 5;
        it.dly  = 10 * (po + (sh ? m + 1 : 0));
        it.high = 10 * (n + 1) + ((dcc && ((n + m) % 2 == 1)) ? 5 : 0);
        it.per  = 10 * (n + m + 2);
        it.tag_d = scramble ? "R7" : (sh ? "R5" : "R4");
        it.tag_h = scramble ? "R7" : ((dcc && ((n + m) % 2 == 1)) ? "R3" : "R2");
        q.push_back(it);
        pushed++;
        if (scramble) begin
            @(negedge clk_i);
            cfg_hi_i  = 4'(n + 7);
            cfg_lo_i  = 4'(m + 3);
            cfg_ofs_i = 4'(po + 5);
            cfg_sh_i  = ~sh;
            cfg_dcc_i = ~dcc;
        end
        wait (done == pushed);
    endtask

    // Monitor: time the first rise, the high time and one period
    initial begin
        item_t it;
        longint tr, tf, tr2;
        forever begin
            wait (q.size() != 0);
            it = q.pop_front();
            @(posedge div_clk_o);
            tr = $time;
            @(negedge div_clk_o);
            tf = $time;
            @(posedge div_clk_o);
            tr2 = $time;
            chk(it.tag_d, "first rise delay", tr - it.t0, it.dly);
            chk(it.tag_h, "high time", tf - tr, it.high);
            chk(it.tag_h, "period", tr2 - tr, it.per);
            done++;
        end
    end

    task automatic hold_check(input bit sh);
        @(negedge clk_i);
        cfg_sh_i = sh;
        sync_i   = 1'b1;
        repeat (2) @(negedge clk_i);
        for (int i = 0; i < 3; i++) begin
            chk("R6", "idle level during sync", longint'(div_clk_o), longint'(sh));
            @(negedge clk_i);
        end
        sync_i = 1'b0;
    endtask

    initial begin
        #2;
        chk("R1", "output in reset", longint'(div_clk_o), 0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk_i);
            chk("R1", "output before first sync", longint'(div_clk_o), 0);
        end

        // R2 / R3: full N x M sweep, both correction settings
        for (int d = 0; d < 2; d++)
            for (int n = 0; n < 16; n++)
                for (int m = 0; m < 16; m++)
                    run_case(n, m, 0, 1'b0, d[0], 1'b0);

        // R4 / R5: every offset with both start levels
        for (int s = 0; s < 2; s++)
            for (int po = 0; po < 16; po++) begin
                run_case(3, 4, po, s[0], 1'b0, 1'b0);
                run_case(15, 15, po, s[0], 1'b0, 1'b0);
                run_case(0, 0, po, s[0], 1'b0, 1'b0);
                run_case(2, 3, po, s[0], 1'b1, 1'b0);
            end

        // R7: configuration changes while running
        run_case(5, 6, 3, 1'b0, 1'b1, 1'b1);
        run_case(9, 2, 7, 1'b1, 1'b0, 1'b1);
        run_case(0, 15, 0, 1'b0, 1'b0, 1'b1);

        // R6: idle level while sync is held
        hold_check(1'b1);
        hold_check(1'b0);
        hold_check(1'b1);

        // R8: bypass follows the input clock
        @(negedge clk_i);
        cfg_bypass_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_i);
            #1 chk("R8", "bypass high level", longint'(div_clk_o), 1);
            @(negedge clk_i);
            #1 chk("R8", "bypass low level", longint'(div_clk_o), 0);
        end
        cfg_bypass_i = 1'b0;

        // Restart after bypass still times correctly
        run_case(4, 5, 2, 1'b0, 1'b1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got %0d done expected %0d", done, pushed);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule